// File: doc/BRIEF.md
# Integer width and sign converter

This block moves an integer between the eight fixed-point formats formed by four sizes (8, 16, 32 and 64 bits) and two signedness choices. It models the integer-to-integer part of a conversion instruction. A value is first brought to the destination format, and the result is then laid into a destination register that may be wider than that format.

Getting to the destination format takes one of three paths. Widening sign-extends or zero-extends according to the source signedness alone. Narrowing keeps only the low bits. A change of signedness at the same size passes the bits through unchanged. If the register is wider than the destination format, the narrowed value is extended a second time, now according to the destination signedness.

The datapath is purely combinational. A register width below 16 bits, or narrower than the destination format, raises an illegal flag and forces the output to zero.

Format encoding on `src_fmt` and `dst_fmt`: bit 2 is the sign (1 = signed), and bits 1:0 are the size code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). `reg_size` uses the same size code for the register width.

Top module: `int_fmt_conv`

## Requirements
- R1: With a signed source format (bit 2 = 1) and a destination size code above the source size code, the destination-format bits above the source width are copies of source bit (source width − 1).
- R2: With an unsigned source format (bit 2 = 0) and a destination size code above the source size code, the destination-format bits above the source width are zero, whatever the destination signedness.
- R3: When the destination size code is below the source size code, the low destination-width bits of `dst_value` equal the low destination-width bits of `src_value`.
- R4: When the source and destination size codes are equal, the low destination-width bits of `dst_value` equal those of `src_value`, for any combination of sign bits.
- R5: When `reg_size` is above the destination size code, the bits of `dst_value` from the destination width up to the register width are copies of result bit (destination width − 1) if the destination format is signed, and are zero if it is unsigned.
- R6: Bits of `dst_value` at or above the register width (16 << (`reg_size` − 1)) are zero.
- R7: `illegal` is 1 exactly when `reg_size` is 0 or `reg_size` is below the destination size code; while it is 1, `dst_value` is all zeros.
- R8: Bits of `src_value` at or above the source format width have no effect on `dst_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_value | input | 64 | Source integer; only the low source-width bits are used |
| src_fmt | input | 3 | Source format: bit 2 is the sign, bits 1:0 the size code |
| dst_fmt | input | 3 | Destination format: bit 2 is the sign, bits 1:0 the size code |
| reg_size | input | 2 | Size code of the destination register (1, 2 or 3 are legal) |
| dst_value | output | 64 | Converted value, zero above the register width |
| illegal | output | 1 | Register width invalid or narrower than the destination format |

## Verification
The embedded checks are immediate assertions evaluated whenever the inputs settle. They assume every input bit is a driven 0 or 1. The bench drives all four inputs together from one task, with defined values only, and compares results half a clock later. The fill and upper-zero properties are asserted only on legal combinations, because an illegal combination is defined to clear the whole output. The bench sweeps every format and register code, so illegal cases are exercised as well.

// File: rtl/int_fmt_pkg.sv
package int_fmt_pkg;
  localparam int DATA_W  = 64;
  localparam int N_SIZES = 4;
  localparam int MIN_W   = 8;

  typedef logic [1:0] size_code_t;

  typedef struct packed {
    logic       is_signed;
    size_code_t size;
  } int_fmt_t;

  function automatic int width_of(input size_code_t code);
    return MIN_W << code;
  endfunction
endpackage

// File: rtl/int_fmt_extend.sv
module int_fmt_extend
  import int_fmt_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] val_i,
  input  size_code_t   size_i,
  input  logic         sign_i,
  output logic [W-1:0] ext_o
);
  logic [W-1:0] cand [N_SIZES];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_fw
    localparam int FW = MIN_W << g;
    if (FW >= W) begin : g_full
      assign cand[g] = val_i;
    end else begin : g_part
      assign cand[g] = {{(W-FW){sign_i & val_i[FW-1]}}, val_i[FW-1:0]};
    end
  end

  assign ext_o = cand[size_i];

  // The field being extended must come out unchanged (R8 source low bits kept)
  always_comb begin
    logic [W-1:0] low_mask;
    int           fw;
    fw = width_of(size_i);
    low_mask = (fw >= W) ? '1 : ((W'(1) << fw) - W'(1));
    a_r8_low_kept: assert (((ext_o ^ val_i) & low_mask) == '0)
      else $error("extend altered kept field");
  end
endmodule

// File: rtl/int_fmt_regmask.sv
module int_fmt_regmask
  import int_fmt_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] val_i,
  input  size_code_t   size_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] cand [N_SIZES];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_rw
    localparam int RW = MIN_W << g;
    if (RW >= W) begin : g_full
      assign cand[g] = val_i;
    end else begin : g_part
      assign cand[g] = {{(W-RW){1'b0}}, val_i[RW-1:0]};
    end
  end

  assign val_o = cand[size_i];
endmodule

// File: rtl/int_fmt_legal.sv
module int_fmt_legal
  import int_fmt_pkg::*;
(
  input  size_code_t reg_size_i,
  input  size_code_t dst_size_i,
  output logic       illegal_o
);
  assign illegal_o = (reg_size_i == 2'd0) || (reg_size_i < dst_size_i);
endmodule

// File: rtl/int_fmt_conv.sv
module int_fmt_conv
  import int_fmt_pkg::*;
(
  input  logic [63:0] src_value,
  input  logic [2:0]  src_fmt,
  input  logic [2:0]  dst_fmt,
  input  logic [1:0]  reg_size,
  output logic [63:0] dst_value,
  output logic        illegal
);
  int_fmt_t        sf;
  int_fmt_t        df;
  logic [DATA_W-1:0] src_wide;
  logic [DATA_W-1:0] dst_wide;
  logic [DATA_W-1:0] reg_val;
  logic              bad;

  assign sf = src_fmt;
  assign df = dst_fmt;

  // Stage 1: source field to full width by source signedness
  int_fmt_extend #(.W(DATA_W)) u_src_ext (
    .val_i (src_value),
    .size_i(sf.size),
    .sign_i(sf.is_signed),
    .ext_o (src_wide)
  );

  // Stage 2: keep destination field, refill by destination signedness
  int_fmt_extend #(.W(DATA_W)) u_dst_ext (
    .val_i (src_wide),
    .size_i(df.size),
    .sign_i(df.is_signed),
    .ext_o (dst_wide)
  );

  int_fmt_regmask #(.W(DATA_W)) u_mask (
    .val_i (dst_wide),
    .size_i(reg_size),
    .val_o (reg_val)
  );

  int_fmt_legal u_legal (
    .reg_size_i(reg_size),
    .dst_size_i(df.size),
    .illegal_o (bad)
  );

  assign illegal   = bad;
  assign dst_value = bad ? '0 : reg_val;

  always_comb begin
    logic [DATA_W-1:0] rmask;
    logic [DATA_W-1:0] fill_exp;
    int                rw;
    int                dw;
    rw = width_of(reg_size);
    dw = width_of(df.size);
    rmask = (rw >= DATA_W) ? '1 : ((DATA_W'(1) << rw) - DATA_W'(1));
    fill_exp = (df.is_signed && dst_value[dw-1]) ? (rmask >> dw) : '0;
    // R7: an illegal combination clears the output
    a_r7_illegal_zero: assert (!illegal || dst_value == '0)
      else $error("illegal output not zero");
    // R6: nothing above the register width
    a_r6_upper_zero: assert (illegal || (dst_value & ~rmask) == '0)
      else $error("bits above register width");
    // R5: register fill follows destination signedness
    a_r5_reg_fill: assert (illegal || dw >= rw || (dst_value >> dw) == fill_exp)
      else $error("register fill wrong");
  end
endmodule

// File: tb/int_fmt_conv_tb.sv
module int_fmt_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [63:0] src;
    logic [2:0]  sf;
    logic [2:0]  df;
    logic [1:0]  rs;
    logic [63:0] expv;
    logic        ill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{64'h80, 3'b100, 3'b110, 2'd2, 64'hFFFF_FF80, 1'b0},                               // R1
    '{64'h80, 3'b000, 3'b110, 2'd2, 64'h80, 1'b0},                                      // R2
    '{64'hBEEF, 3'b001, 3'b110, 2'd2, 64'hBEEF, 1'b0},                                  // R2
    '{64'h1234_8765, 3'b010, 3'b101, 2'd2, 64'hFFFF_8765, 1'b0},                        // R5
    '{64'h1234_8765, 3'b010, 3'b001, 2'd2, 64'h8765, 1'b0},                             // R5
    '{64'hFFFF_FFFF_0000_00AB, 3'b111, 3'b000, 2'd1, 64'hAB, 1'b0},                     // R3
    '{64'h8000_0001, 3'b110, 3'b010, 2'd2, 64'h8000_0001, 1'b0},                        // R4
    '{64'h8000_0000_0000_0000, 3'b011, 3'b111, 2'd3, 64'h8000_0000_0000_0000, 1'b0},    // R4
    '{64'hDEAD_BEEF_CAFE_127F, 3'b100, 3'b111, 2'd3, 64'h7F, 1'b0},                     // R8
    '{64'h1234_AAFF, 3'b100, 3'b001, 2'd3, 64'hFFFF, 1'b0},                             // R1 R5
    '{64'h8001, 3'b101, 3'b100, 2'd3, 64'h1, 1'b0},                                     // R3
    '{64'h0080, 3'b101, 3'b100, 2'd3, 64'hFFFF_FFFF_FFFF_FF80, 1'b0},                   // R3 R5
    '{64'hFF, 3'b000, 3'b101, 2'd1, 64'hFF, 1'b0},                                      // R2
    '{64'h80, 3'b100, 3'b101, 2'd1, 64'hFF80, 1'b0},                                    // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 3'b111, 3'b110, 2'd2, 64'hFFFF_FFFF, 1'b0},              // R6
    '{64'h55, 3'b000, 3'b000, 2'd0, 64'h0, 1'b1},                                       // R7
    '{64'h55, 3'b000, 3'b110, 2'd1, 64'h0, 1'b1},                                       // R7
    '{64'h55, 3'b000, 3'b011, 2'd2, 64'h0, 1'b1},                                       // R7
    '{64'h8000_0000, 3'b110, 3'b111, 2'd3, 64'hFFFF_FFFF_8000_0000, 1'b0},              // R1
    '{64'hFFFF_0000_1234_FFFF, 3'b001, 3'b011, 2'd3, 64'hFFFF, 1'b0}                    // R8
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] src_value;
  logic [2:0]  src_fmt;
  logic [2:0]  dst_fmt;
  logic [1:0]  reg_size;
  logic [63:0] dst_value;
  logic        illegal;
  int          checks;
  int          failures;
  int          cycles;
  bit          done;

  int_fmt_conv u_dut (
    .src_value(src_value),
    .src_fmt  (src_fmt),
    .dst_fmt  (dst_fmt),
    .reg_size (reg_size),
    .dst_value(dst_value),
    .illegal  (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model: arithmetic shifts instead of field selection
  function automatic logic [63:0] fit(input logic [63:0] v, input int w, input bit sgn);
    logic [63:0] t;
    if (w >= 64) return v;
    t = v << (64 - w);
    return sgn ? 64'($signed(t) >>> (64 - w)) : (t >> (64 - w));
  endfunction

  function automatic logic [64:0] model(input logic [63:0] s, input logic [2:0] f_s,
                                        input logic [2:0] f_d, input logic [1:0] r);
    logic [63:0] v;
    int          wr;
    if (r == 2'd0 || r < f_d[1:0]) return 65'h1_0000_0000_0000_0000;
    v  = fit(s, 8 << f_s[1:0], f_s[2]);
    v  = fit(v, 8 << f_d[1:0], f_d[2]);
    wr = 8 << r;
    if (wr < 64) v = v & ((64'd1 << wr) - 64'd1);
    return {1'b0, v};
  endfunction

  task automatic apply(input logic [63:0] s, input logic [2:0] f_s,
                       input logic [2:0] f_d, input logic [1:0] r);
    @(posedge clk);
    src_value = s;
    src_fmt   = f_s;
    dst_fmt   = f_d;
    reg_size  = r;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] ev, input logic ei);
    checks++;
    if (dst_value !== ev || illegal !== ei) begin
      failures++;
      $display("FAIL %s: got value=%h illegal=%b expected value=%h illegal=%b",
               tag, dst_value, illegal, ev, ei);
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    src_value = '0;
    src_fmt = '0;
    dst_fmt = '0;
    reg_size = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: all-zero inputs give an 8-bit register code, which is illegal
    check("R7 idle inputs", 64'h0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].src, VECS[i].sf, VECS[i].df, VECS[i].rs);
      check($sformatf("vector %0d (tags in table)", i), VECS[i].expv, VECS[i].ill);
    end

    // Exhaustive sweep of formats and register codes: R1 R2 R3 R4 R5 R6 R7 R8
    for (int p = 0; p < 4; p++) begin
      logic [63:0] pat;
      case (p)
        0: pat = 64'hF0E1_D2C3_B4A5_9687;
        1: pat = 64'h0123_4567_89AB_CDEF;
        2: pat = 64'h7FFF_7FFF_7FFF_7F7F;
        default: pat = 64'h8000_8000_8000_8080;
      endcase
      for (int fs = 0; fs < 8; fs++) begin
        for (int fd = 0; fd < 8; fd++) begin
          for (int r = 0; r < 4; r++) begin
            logic [64:0] m;
            m = model(pat, 3'(fs), 3'(fd), 2'(r));
            apply(pat, 3'(fs), 3'(fd), 2'(r));
            check($sformatf("sweep R1..R8 pat%0d sf%0d df%0d rs%0d", p, fs, fd, r),
                  m[63:0], m[64]);
          end
        end
      end
    end

    // R8: upper source garbage changes nothing
    apply(64'h0000_0000_0000_00C3, 3'b100, 3'b111, 2'd3);
    check("R8 clean upper", 64'hFFFF_FFFF_FFFF_FFC3, 1'b0);
    apply(64'h5A5A_5A5A_5A5A_5AC3, 3'b100, 3'b111, 2'd3);
    check("R8 dirty upper", 64'hFFFF_FFFF_FFFF_FFC3, 1'b0);
    // R4: signed to unsigned at the same size, 16-bit register
    apply(64'h0000_0000_0000_8000, 3'b101, 3'b001, 2'd1);
    check("R4 s16 to u16", 64'h8000, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        checks++;
        failures++;
        $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule